// File: doc/BRIEF.md
# Memory Array Summation Accelerator

This block is a fixed-function engine that totals a run of consecutive words held in a data memory. After a start pulse it walks an index from 1 up to a word count N. It reads each location through a synchronous read port and folds the returned word into a running total. The block fetches no instructions. A small hardwired state machine steers an index register, a word-count register and a total register that feeds one adder.

The host places the words at addresses 1..N and drives N on `count_i`. It then pulses `start_i` while the engine is idle and waits for the one-cycle `done_o` pulse. After that pulse it reads `total_o`. The memory answers a read strobe with data on the following clock edge, so the engine spends two cycles on each word: one to issue the address and one to add the data.

Top module: `mem_sum_accel`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `busy_o`, `done_o` and `mem_rd_o` are 0 and `total_o` is 0.
- R2: A `start_i` pulse is accepted only when `busy_o` is 0. A pulse seen while busy changes neither the read sequence, the done timing nor the total.
- R3: In the cycle after an accepted start, `total_o` reads 0. This holds whatever total the previous run left.
- R4: For N > 0, `mem_rd_o` is high in cycles 1, 3, …, 2N-1 counted from the edge that accepted start. In read k of those cycles, `mem_addr_o` equals k, so the addresses run 1, 2, …, N in rising order. `mem_rd_o` is never high in two cycles in a row.
- R5: The word returned in the cycle after each read is added into `total_o` at the next edge. During a run, `total_o` in cycle t equals the sum of the first floor((t-1)/2) words.
- R6: `done_o` is high for exactly one cycle, in cycle 2N+1 after the accepted start. In that cycle `total_o` equals the sum of words 1..N.
- R7: When `busy_o` is 0, `total_o` holds its last value and no read is issued until the next accepted start.
- R8: When N = 0, `done_o` rises in cycle 1 after start, with `total_o` = 0 and no memory read.
- R9: The total is `DATA_W` bits wide and wraps modulo 2^`DATA_W` on overflow.
- R10: `count_i` is sampled only at the accepted start. Later changes to it do not alter the running job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| count_i | input | ADDR_W | Number of words N to add |
| mem_addr_o | output | ADDR_W | Read address to the data memory |
| mem_rd_o | output | 1 | Read strobe; data is due one cycle later |
| mem_rdata_i | input | DATA_W | Read data, registered by the memory |
| busy_o | output | 1 | High from the accepted start through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| total_o | output | DATA_W | Running and final total |

## Verification
Cycles are counted from the edge that accepts start, which is cycle 0. For N words, the k-th read strobe is due in cycle 2k-1. The total reflects k added words from cycle 2k+1 onward. The done pulse is due in cycle 2N+1, or in cycle 1 when N is 0. The bench keeps one integer of elapsed cycles and builds a prefix-sum table of the memory when it sees the start. Each cycle it works out the expected strobe, address, done and total from those values. It compares them with the outputs on the falling edge, so each result is sampled in the cycle it is due and never at the edge that produces it.

// File: rtl/msum_pkg.sv
package msum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_ACCUM = 2'd2,
        ST_DONE  = 2'd3
    } msum_state_e;

    typedef struct packed {
        logic clr;   // zero the total
        logic load;  // capture count, set index to first address
        logic rd;    // present read strobe
        logic acc;   // add returned word
        logic step;  // advance index
    } msum_ctl_t;

endpackage

// File: rtl/msum_ctrl.sv
module msum_ctrl
    import msum_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        n_zero_i,
    input  logic        last_i,
    output msum_ctl_t   ctl_o,
    output msum_state_e state_o
);

    typedef struct packed {
        msum_state_e st;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;
    msum_ctl_t ctl;

    always_comb begin
        r_d = r_q;
        ctl = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl.clr  = 1'b1;
                    ctl.load = 1'b1;
                    r_d.st   = n_zero_i ? ST_DONE : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                ctl.rd = 1'b1;
                r_d.st = ST_ACCUM;
            end
            ST_ACCUM: begin
                ctl.acc = 1'b1;
                if (last_i) begin
                    r_d.st = ST_DONE;
                end else begin
                    ctl.step = 1'b1;
                    r_d.st   = ST_ISSUE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE};
        else        r_q <= r_d;
    end

    assign ctl_o   = ctl;
    assign state_o = r_q.st;

endmodule

// File: rtl/msum_dp.sv
module msum_dp #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              acc_i,
    input  logic [ADDR_W-1:0] count_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] idx_o,
    output logic              last_o,
    output logic              n_zero_o,
    output logic [DATA_W-1:0] total_o
);

    localparam logic [ADDR_W-1:0] FIRST_IDX = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] IDX_STEP  = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] n;
        logic [DATA_W-1:0] total;
    } dp_reg_t;

    dp_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i)  r_d.total = '0;
        if (load_i) begin
            r_d.idx = FIRST_IDX;
            r_d.n   = count_i;
        end
        if (step_i) r_d.idx   = r_q.idx + IDX_STEP;
        if (acc_i)  r_d.total = r_q.total + rdata_i;   // wraps at DATA_W
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign idx_o    = r_q.idx;
    assign last_o   = (r_q.idx == r_q.n);
    assign n_zero_o = (count_i == '0);
    assign total_o  = r_q.total;

endmodule

// File: rtl/mem_sum_accel.sv
module mem_sum_accel #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] count_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] total_o
);
    import msum_pkg::*;

    msum_ctl_t   ctl;
    msum_state_e state;
    logic        last;
    logic        n_zero;

    msum_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .n_zero_i (n_zero),
        .last_i   (last),
        .ctl_o    (ctl),
        .state_o  (state)
    );

    msum_dp #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (ctl.clr),
        .load_i   (ctl.load),
        .step_i   (ctl.step),
        .acc_i    (ctl.acc),
        .count_i  (count_i),
        .rdata_i  (mem_rdata_i),
        .idx_o    (mem_addr_o),
        .last_o   (last),
        .n_zero_o (n_zero),
        .total_o  (total_o)
    );

    assign mem_rd_o = ctl.rd;
    assign busy_o   = (state != ST_IDLE);
    assign done_o   = (state == ST_DONE);

endmodule

// File: rtl/msum_chk.sv
module msum_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] count_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rd_o,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] total_o
);

    logic [DATA_W-1:0] sum_prev;
    always_ff @(posedge clk) sum_prev <= total_o + mem_rdata_i;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o); // R4
    AST_ADDR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (mem_addr_o != '0)); // R4
    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (total_o == '0)); // R3
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && count_i == '0) |=> (done_o && !mem_rd_o)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(total_o) && !mem_rd_o)); // R7
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R2
    AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rd_o, 2) |-> (total_o == sum_prev)); // R5

endmodule

bind mem_sum_accel msum_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .count_i     (count_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .total_o     (total_o)
);

// File: tb/tb_mem_sum_accel.sv
module tb_mem_sum_accel;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 8;
    localparam int MEM_D    = 1 << ADDR_W;
    localparam int CLK_PER  = 10;
    localparam int WD_LIMIT = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] count_i = '0;
    logic [ADDR_W-1:0] mem_addr_o;
    logic              mem_rd_o;
    logic [DATA_W-1:0] mem_rdata_i = '0;
    logic              busy_o, done_o;
    logic [DATA_W-1:0] total_o;

    always #(CLK_PER/2) clk = ~clk;

    mem_sum_accel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .total_o(total_o)
    );

    // data memory with one cycle read latency
    logic [DATA_W-1:0] mem [MEM_D];
    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s] act=%0d exp=%0d t=%0t", what, cur_tag, act, exp, $time);
        end
    endtask

    task automatic report();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // behavioural reference: elapsed cycles since accepted start + prefix sums
    bit                act = 0;
    int                t = 0;
    int                rn = 0;
    logic [DATA_W-1:0] hold = '0;
    logic [DATA_W-1:0] pre [MEM_D];

    always @(posedge clk) begin
        if (!rst_n) begin
            act = 0; t = 0; hold = '0;
        end else if (act) begin
            if (t == 2*rn + 1) begin act = 0; hold = pre[rn]; end
            else t = t + 1;
        end else if (start_i) begin
            act = 1; t = 1; rn = int'(count_i);
            pre[0] = '0;
            for (int j = 1; j <= rn; j++) pre[j] = pre[j-1] + mem[j];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit                e_rd, e_done, e_busy;
            logic [DATA_W-1:0] e_tot;
            e_busy = act;
            e_rd   = act && (t % 2 == 1) && (t < 2*rn + 1);
            e_done = act && (t == 2*rn + 1);
            e_tot  = act ? pre[(t-1)/2] : hold;
            chk(busy_o == e_busy, "R2 busy", 64'(busy_o), 64'(e_busy));
            chk(mem_rd_o == e_rd, "R4 read strobe", 64'(mem_rd_o), 64'(e_rd));
            if (e_rd)
                chk(mem_addr_o == ADDR_W'((t+1)/2), "R4 address",
                    64'(mem_addr_o), 64'((t+1)/2));
            chk(done_o == e_done, "R6 done", 64'(done_o), 64'(e_done));
            chk(total_o == e_tot, act ? "R3/R5 total" : "R7 held total",
                64'(total_o), 64'(e_tot));
        end
    end

    task automatic launch(input int n);
        @(negedge clk);
        count_i = ADDR_W'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic finish_run(input int n);
        while (busy_o) @(negedge clk);
        chk(total_o == pre[n], "R6 final total", 64'(total_o), 64'(pre[n]));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEM_D; i++) mem[i] = DATA_W'(i * 37 + 5);
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        chk(!busy_o && !done_o && !mem_rd_o, "R1 reset outputs", 64'(busy_o), 64'(0));
        chk(total_o == '0, "R1 reset total", 64'(total_o), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && total_o == '0, "R1 after reset", 64'(total_o), 64'(0));

        cur_tag = "R5 N=3";  launch(3);  finish_run(3);
        cur_tag = "R5 N=1";  launch(1);  finish_run(1);
        cur_tag = "R8 N=0";  launch(0);  finish_run(0);
        chk(total_o == '0, "R8 zero count total", 64'(total_o), 64'(0));

        // start and count changes during a busy run are ignored
        cur_tag = "R2/R10 N=5";
        launch(5);
        repeat (3) @(negedge clk);
        count_i = ADDR_W'(9);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        count_i = ADDR_W'(2);
        finish_run(5);

        // overflow wraps
        cur_tag = "R9 wrap";
        for (int i = 1; i <= 4; i++) mem[i] = '1;
        launch(4);  finish_run(4);
        chk(total_o == DATA_W'(16'hFFFC), "R9 wrapped total", 64'(total_o), 64'(16'hFFFC));

        cur_tag = "R9 N=max";
        for (int i = 0; i < MEM_D; i++) mem[i] = DATA_W'(i * 1009 + 77);
        launch(MEM_D - 1);  finish_run(MEM_D - 1);

        cur_tag = "R3 restart N=2";
        launch(2);  finish_run(2);

        cur_tag = "R7 idle";
        repeat (10) @(negedge clk);
        report();
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired act=1 exp=0");
            report();
        end
    end
endmodule